// File: doc/BRIEF.md
# Pruned Block-Matching Motion Search Engine

The engine finds the best horizontal match for one 16x16 current block among 32 candidate displacements of one search-window row band. It uses a one-dimensional systolic row of 32 processing elements, one per candidate. Each element accumulates the sum of absolute differences (SAD) between the current block and its displaced window, one block row at a time. A shift register of window pixels lines up each element with its own displacement, so one current pixel is broadcast to all elements per cycle.

Every fourth row is a checkpoint. At a checkpoint the engine ranks the partial SADs and switches off the weaker candidates, so only the promising ones keep accumulating. Every element is still instantiated, because no candidate can be ruled out before its data is seen. A switched-off element freezes its accumulator and raises its clock-gate request. Three selections are available: no pruning (exhaustive), a global ranking, and a cheaper local one that compares neighbouring survivors only. After the sixteenth row the engine reports the winning displacement and its SAD with a one-cycle done pulse.

The driver pushes, for each block row, the window row of 16+32-1 = 47 pixels, one per cycle. From push 31 onward it also presents the current pixel of column (push index - 31). After the last push of rows 4, 8 and 12 it leaves at least one idle cycle before the next push.

Top module: `pds_engine`

## Requirements
- R1: After reset, done_o is 0, mv_o and sad_o are 0 and pe_gate_o is all zeros.
- R2: Candidate k (0..31) accumulates |cur(r,c) - win(r,c+k)| over all rows r and columns c. Per row, win_vld_i pushes window columns 0..46 in order. The current pixel of column c is sampled with the push of window column c+31.
- R3: mode_i is sampled on start_i, which also clears all sums and re-enables all candidates. The encodings are 0 = no pruning, 1 = global ranking, 2 = local ranking, and 3 behaves as 0.
- R4: With no pruning, the result equals an exhaustive minimum over all 32 candidates, and pe_gate_o stays all zeros.
- R5: Checkpoints follow the last push of rows 4, 8 and 12 only. The new enable set is visible on pe_gate_o one cycle after that push.
- R6: In global mode a checkpoint keeps the half of the active candidates with the smallest partial SAD and gates the rest.
- R7: In local mode, checkpoint number n (0, 1, 2) splits the candidates into aligned groups of 2^(n+1) indices. Only the active candidate with the smallest partial SAD in each group survives.
- R8: In every ranking and in the final choice, equal SADs are resolved in favour of the lower index.
- R9: A gated candidate shows a 1 on its pe_gate_o bit, keeps its SAD frozen, and is not re-enabled before the next start_i.
- R10: The result is the active candidate with the smallest final SAD. mv_o = index - 16 in two's complement, and sad_o is that candidate's SAD.
- R11: done_o is high for exactly one cycle: the cycle that follows the edge after the last push of row 16. mv_o and sad_o are valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new block, samples mode_i |
| mode_i | input | 2 | Pruning selection: 0 none, 1 global, 2 local |
| win_vld_i | input | 1 | A window pixel is pushed this cycle |
| win_pix_i | input | 8 | Search-window pixel |
| cur_pix_i | input | 8 | Current-block pixel, used from push 31 of each row |
| done_o | output | 1 | One-cycle result strobe |
| mv_o | output | 6 | Winning displacement, signed (-16..15) |
| sad_o | output | 16 | SAD of the winning candidate |
| pe_gate_o | output | 32 | Per-element clock-gate request, 1 = element off |

## Verification
Random blocks in all three modes check the accumulation alignment and the pruning order against an arithmetic model. A flat all-equal block makes every comparison a tie, which separates the lower-index rule from any other tie choice. A window that holds an exact copy of the block at one displacement must give SAD 0 at that displacement in every mode. A block that is worst at first and best later exposes early pruning: the global result must then differ from the exhaustive one exactly as the model predicts.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    PRUNE_OFF    = 2'd0,
    PRUNE_GLOBAL = 2'd1,
    PRUNE_LOCAL  = 2'd2
  } prune_mode_e;
endpackage

// File: rtl/pds_pe.sv
module pds_pe #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] ref_i,
  output logic [SAD_W-1:0] acc_o
);
  logic [PIX_W-1:0] diff;
  assign diff = (cur_i >= ref_i) ? (cur_i - ref_i) : (ref_i - cur_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (clr_i)   acc_o <= '0;
    else if (en_i)    acc_o <= acc_o + SAD_W'(diff);
  end

  assert_hold_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(acc_o));
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int NUM_PE = 32,
  parameter int BLK    = 16,
  parameter int CHK    = 4,
  parameter int LVL_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             win_vld_i,
  output logic             acc_en_o,
  output logic             ckpt_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             fin_o,
  output prune_mode_e      mode_o
);
  localparam int ROW_LEN = BLK + NUM_PE - 1;
  localparam int COL_W   = $clog2(ROW_LEN);
  localparam int ROW_W   = $clog2(BLK) + 1;

  logic             busy_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_nx;
  logic             row_last;

  assign row_nx   = row_q + 1'b1;
  assign row_last = busy_q && win_vld_i && (col_q == COL_W'(ROW_LEN - 1));
  assign acc_en_o = busy_q && win_vld_i && (col_q >= COL_W'(NUM_PE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
      ckpt_o <= 1'b0;
      lvl_o  <= '0;
      fin_o  <= 1'b0;
      mode_o <= PRUNE_OFF;
    end else begin
      ckpt_o <= 1'b0;
      fin_o  <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        col_q  <= '0;
        row_q  <= '0;
        case (mode_i)
          2'd1:    mode_o <= PRUNE_GLOBAL;
          2'd2:    mode_o <= PRUNE_LOCAL;
          default: mode_o <= PRUNE_OFF;
        endcase
      end else if (busy_q && win_vld_i) begin
        if (row_last) begin
          col_q <= '0;
          row_q <= row_nx;
          if (row_nx == ROW_W'(BLK)) begin
            busy_q <= 1'b0;
            fin_o  <= 1'b1;
          end else if ((int'(row_nx) % CHK == 0) && (mode_o != PRUNE_OFF)) begin
            ckpt_o <= 1'b1;
            lvl_o  <= LVL_W'(int'(row_nx) / CHK - 1);
          end
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assert_fin_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);
  assert_ckpt_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_o |-> (mode_o != PRUNE_OFF) && !fin_o);
endmodule

// File: rtl/pds_prune.sv
module pds_prune #(
  parameter int NUM_PE = 32,
  parameter int SAD_W  = 16,
  parameter int LVL_W  = 2
) (
  input  logic [NUM_PE-1:0][SAD_W-1:0] acc_i,
  input  logic [NUM_PE-1:0]            active_i,
  input  logic                         global_i,
  input  logic [LVL_W-1:0]             lvl_i,
  output logic [NUM_PE-1:0]            keep_o
);
  logic [NUM_PE-1:0] keep_g, keep_l;

  always_comb begin
    int n_act;
    int half;
    int sh;
    n_act = 0;
    for (int i = 0; i < NUM_PE; i++) n_act += int'(active_i[i]);
    half = (n_act + 1) / 2;
    sh   = int'(lvl_i) + 1;
    for (int i = 0; i < NUM_PE; i++) begin
      int  rank;
      logic lose;
      rank = 0;
      lose = 1'b0;
      for (int j = 0; j < NUM_PE; j++) begin
        if (j != i && active_i[j] &&
            ((acc_i[j] < acc_i[i]) || ((acc_i[j] == acc_i[i]) && (j < i)))) begin
          rank++;
          if ((i >> sh) == (j >> sh)) lose = 1'b1;
        end
      end
      keep_g[i] = active_i[i] && (rank < half);
      keep_l[i] = active_i[i] && !lose;
    end
  end

  assign keep_o = global_i ? keep_g : keep_l;
endmodule

// File: rtl/pds_engine.sv
module pds_engine
  import pds_pkg::*;
#(
  parameter int NUM_PE = 32,
  parameter int BLK    = 16,
  parameter int CHK    = 4,
  parameter int PIX_W  = 8,
  localparam int IDX_W = $clog2(NUM_PE),
  localparam int MV_W  = IDX_W + 1,
  localparam int SAD_W = $clog2(BLK * BLK * ((1 << PIX_W) - 1) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              win_vld_i,
  input  logic [PIX_W-1:0]  win_pix_i,
  input  logic [PIX_W-1:0]  cur_pix_i,
  output logic              done_o,
  output logic [MV_W-1:0]   mv_o,
  output logic [SAD_W-1:0]  sad_o,
  output logic [NUM_PE-1:0] pe_gate_o
);
  localparam int NUM_CKPT = BLK / CHK - 1;
  localparam int LVL_W    = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1;

  logic                         acc_en, ckpt, fin;
  logic [LVL_W-1:0]             lvl;
  prune_mode_e                  mode;
  logic [NUM_PE-2:0][PIX_W-1:0] sr_q;
  logic [NUM_PE-1:0][PIX_W-1:0] wv;
  logic [NUM_PE-1:0][SAD_W-1:0] acc;
  logic [NUM_PE-1:0]            active_q, keep;
  logic [IDX_W-1:0]             best_idx;
  logic [SAD_W-1:0]             best_sad;

  pds_ctrl #(.NUM_PE(NUM_PE), .BLK(BLK), .CHK(CHK), .LVL_W(LVL_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i, .win_vld_i,
    .acc_en_o(acc_en), .ckpt_o(ckpt), .lvl_o(lvl), .fin_o(fin), .mode_o(mode)
  );

  // window delay line: wv[j] is the pixel pushed j cycles ago
  assign wv[0] = win_pix_i;
  for (genvar j = 1; j < NUM_PE; j++) begin : g_wv
    assign wv[j] = sr_q[j-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (win_vld_i) sr_q <= wv[NUM_PE-2:0];
  end

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    pds_pe #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_pe (
      .clk_i, .rst_ni,
      .clr_i (start_i),
      .en_i  (acc_en && active_q[k]),
      .cur_i (cur_pix_i),
      .ref_i (wv[NUM_PE-1-k]),
      .acc_o (acc[k])
    );
  end

  pds_prune #(.NUM_PE(NUM_PE), .SAD_W(SAD_W), .LVL_W(LVL_W)) u_prune (
    .acc_i(acc), .active_i(active_q), .global_i(mode == PRUNE_GLOBAL),
    .lvl_i(lvl), .keep_o(keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= '1;
    else if (start_i) active_q <= '1;
    else if (ckpt)    active_q <= keep;
  end

  always_comb begin
    best_idx = '0;
    best_sad = '1;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (active_q[i] && acc[i] <= best_sad) begin
        best_idx = IDX_W'(i);
        best_sad = acc[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      mv_o   <= '0;
      sad_o  <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        mv_o  <= {1'b0, best_idx} - MV_W'(NUM_PE / 2);
        sad_o <= best_sad;
      end
    end
  end

  assign pe_gate_o = ~active_q;

  logic [IDX_W-1:0] win_idx;
  assign win_idx = IDX_W'(mv_o + MV_W'(NUM_PE / 2));

  assert_no_reenable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((active_q & ~$past(active_q)) == '0));
  assert_half_pruned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ckpt && !start_i) |=> ($countones(active_q) == $countones($past(active_q)) / 2));
  assert_off_no_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PRUNE_OFF && !start_i) |=> $stable(active_q));
  assert_winner_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pe_gate_o[win_idx]);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_pds_engine.sv
module tb_pds_engine;
  localparam int NPE = 32;
  localparam int BK  = 16;
  localparam int RL  = BK + NPE - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        win_vld_i = 1'b0;
  logic [7:0]  win_pix_i = '0;
  logic [7:0]  cur_pix_i = '0;
  logic        done_o;
  logic [5:0]  mv_o;
  logic [15:0] sad_o;
  logic [31:0] pe_gate_o;

  int n_chk = 0;
  int n_fail = 0;
  int cur [BK][BK];
  int win [BK][RL];
  logic [31:0] exp_mask [3];
  int exp_idx, exp_sad;

  always #2 clk_i = ~clk_i;

  pds_engine dut (.*);

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int ad(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // arithmetic model of the requirements
  task automatic model(int md);
    int s [NPE];
    bit act [NPE];
    int ck;
    ck = 0;
    for (int k = 0; k < NPE; k++) begin s[k] = 0; act[k] = 1; end
    for (int r = 0; r < BK; r++) begin
      for (int k = 0; k < NPE; k++)
        if (act[k]) for (int c = 0; c < BK; c++) s[k] += ad(cur[r][c], win[r][c+k]);
      if ((r + 1) % 4 == 0 && r != BK - 1) begin
        bit nx [NPE];
        int n;
        n = 0;
        for (int k = 0; k < NPE; k++) n += act[k];
        for (int i = 0; i < NPE; i++) begin
          int rk; bit lose;
          rk = 0; lose = 0;
          for (int j = 0; j < NPE; j++)
            if (j != i && act[j] && (s[j] < s[i] || (s[j] == s[i] && j < i))) begin
              rk++;
              if ((i >> (ck + 1)) == (j >> (ck + 1))) lose = 1;
            end
          if (md == 1)      nx[i] = act[i] && rk < n / 2;
          else if (md == 2) nx[i] = act[i] && !lose;
          else              nx[i] = act[i];
        end
        for (int i = 0; i < NPE; i++) begin
          act[i] = nx[i];
          exp_mask[ck][i] = !nx[i];
        end
        ck++;
      end
    end
    exp_idx = -1;
    for (int k = 0; k < NPE; k++)
      if (act[k] && (exp_idx < 0 || s[k] < exp_sad)) begin exp_idx = k; exp_sad = s[k]; end
  endtask

  task automatic run(int md, string tag);
    int ck;
    ck = 0;
    model(md);
    @(negedge clk_i); start_i = 1'b1; mode_i = 2'(md);
    @(negedge clk_i); start_i = 1'b0;
    for (int r = 0; r < BK; r++) begin
      for (int p = 0; p < RL; p++) begin
        win_vld_i = 1'b1;
        win_pix_i = 8'(win[r][p]);
        cur_pix_i = (p >= NPE - 1) ? 8'(cur[r][p-NPE+1]) : 8'h00;
        @(negedge clk_i);
      end
      win_vld_i = 1'b0;
      if (r == BK - 1) begin
        chk({"R11 done low early ", tag}, int'(done_o), 0);
        @(negedge clk_i);
        chk({"R11 done high ", tag}, int'(done_o), 1);
        chk({"R10 mv ", tag}, int'($signed(mv_o)), exp_idx - 16);
        chk({"R10 sad ", tag}, int'(sad_o), exp_sad);
        @(negedge clk_i);
        chk({"R11 done one cycle ", tag}, int'(done_o), 0);
      end else if ((r + 1) % 4 == 0) begin
        @(negedge clk_i);
        chk({"R5 R6 R7 gate mask ", tag}, int'(pe_gate_o), int'(exp_mask[ck]));
        ck++;
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #7;
    chk("R1 done", int'(done_o), 0);
    chk("R1 mv", int'(mv_o), 0);
    chk("R1 sad", int'(sad_o), 0);
    chk("R1 gate", int'(pe_gate_o), 0);
    rst_ni = 1'b1;

    // random, R2 R4: exhaustive result with no pruning (mode 0 and 3)
    for (int r = 0; r < BK; r++) begin
      for (int c = 0; c < BK; c++) cur[r][c] = int'($urandom_range(0, 255));
      for (int c = 0; c < RL; c++) win[r][c] = int'($urandom_range(0, 255));
    end
    run(0, "R2 R4 random off");
    chk("R4 gate stays off", int'(pe_gate_o), 0);
    run(3, "R3 mode3 as off");
    run(1, "R6 random global");
    run(2, "R7 random local");

    // flat block: every comparison ties, R8
    for (int r = 0; r < BK; r++) begin
      for (int c = 0; c < BK; c++) cur[r][c] = 50;
      for (int c = 0; c < RL; c++) win[r][c] = 50;
    end
    run(0, "R8 tie off");
    run(1, "R8 tie global");
    run(2, "R8 tie local");

    // exact copy at displacement 9
    for (int r = 0; r < BK; r++) begin
      for (int c = 0; c < BK; c++) cur[r][c] = int'($urandom_range(0, 255));
      for (int c = 0; c < RL; c++) win[r][c] = int'($urandom_range(0, 255));
      for (int c = 0; c < BK; c++) win[r][c+9] = cur[r][c];
    end
    run(1, "R10 match global");
    run(2, "R10 match local");
    run(0, "R10 match off");

    // late bloomer: rows 0..3 differ strongly, later rows match at k=3
    for (int r = 0; r < BK; r++) begin
      for (int c = 0; c < BK; c++) cur[r][c] = (r < 4) ? 0 : (c * 13 + r * 7) % 256;
      for (int c = 0; c < RL; c++) win[r][c] = (r < 4) ? ((c == 3 + 8) ? 255 : 0) : 128;
      if (r >= 4) for (int c = 0; c < BK; c++) win[r][c+3] = cur[r][c];
    end
    run(1, "R9 late global");
    run(0, "R9 late off");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule